// File: doc/BRIEF.md
# Serial Control Port Register File

This block is the slave side of a four-wire serial control port for a converter front end. A host frames each transfer by pulling a strobe low. It then clocks a 16-bit word in, most significant bit first. The word holds a 4-bit register address, a direction flag, one reserved bit and a 10-bit payload. When the strobe returns high, a well-formed write lands in a small register file. A read request instead streams the addressed register's payload back on the serial output, while the host is still clocking the word in.

Register 0 is the control register of the front end and is write-only. Its fields are presented as parallel outputs: peak-read enable, high-pass enable, power-down, modulator clock select, and a 3-bit gain code for each channel. Each gain code also comes out decoded to a gain in dB. The other registers, at addresses 1 up to the register count minus one, are plain read/write storage. All four serial pins are oversampled by the system clock and pass through a two-stage synchronizer, so the serial clock can run asynchronously to that clock, at well below a quarter of its rate.

Top module: `ctrl_serial_regfile`

## Requirements
- R1: Words are shifted in on `ser_din` most significant bit first: bits 15–12 are the address, bit 11 is the direction, bit 10 is reserved and bits 9–0 are the payload. A write to address 0 drives `peak_en` from bit 9, `hpf_en` from bit 8, `pwr_down` from bit 7 and `mod_clk_64x` from bit 6.
- R2: In register 0, payload bits 5–3 appear on `gain_code_l` and bits 2–0 on `gain_code_r`, and the two channels are set independently.
- R3: Each decoded gain is 0, 3, 6, 9 or 12 dB for codes 0, 1, 2, 3 or 4. Codes 5, 6 and 7 decode to 0 dB.
- R4: After reset, every register 0 output and `ser_dout` is 0.
- R5: A frame updates a register only if exactly 16 serial clock rising edges occur while the strobe is low. A frame of 15 or 17 bits changes nothing.
- R6: A direction bit of 1 requests a read, and 0 requests a write. In a read frame, the payload of the addressed register (1..NUM_REGS-1) is driven on `ser_dout`, bit 9 first. Each bit is driven after the serial clock falling edge that precedes the rising edge of payload bit times 7 to 16.
- R7: `ser_dout` is 0 during the header bit times of a read frame, after the 16th bit, while the strobe is high, and throughout write frames.
- R8: A read of address 0 returns all zeros and leaves register 0 unchanged.
- R9: Writes to addresses at or above NUM_REGS (default 4) are ignored, and reads of them return zeros. The reserved bit has no effect on what is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_frame | input | 1 | Frame strobe, low during a transfer |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| peak_en | output | 1 | Peak reading enable (register 0 bit 9) |
| hpf_en | output | 1 | High-pass filter enable (register 0 bit 8) |
| pwr_down | output | 1 | Power-down request (register 0 bit 7) |
| mod_clk_64x | output | 1 | 1 selects the 64x modulator clock, 0 selects 128x (bit 6) |
| gain_code_l | output | 3 | Left channel gain code (bits 5–3) |
| gain_code_r | output | 3 | Right channel gain code (bits 2–0) |
| gain_db_l | output | 4 | Left channel gain in dB |
| gain_db_r | output | 4 | Right channel gain in dB |

## Verification
Two register 0 patterns with complementary flag bits show that each payload bit reaches its own output and not its neighbour's. A sweep that sets the left gain code to c and the right to 7-c covers every code on each channel and exposes any crosstalk between channels or an error in the dB decode. Frames of 15 and 17 bits separate an exact length check from a minimum length check. Read-back of distinct values from every storage register, plus reads of address 0 and of an unimplemented address, checks both the output timing and the all-zero returns. Writes with the reserved bit set and writes to an address out of range confirm that both are ignored.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 10;
  localparam int NUM_REGS = 4;
  localparam int CNT_W    = $clog2(WORD_W + 2);

  typedef struct packed {
    logic       peak;
    logic       hpf;
    logic       pdn;
    logic       mclk64;
    logic [2:0] gain_l;
    logic [2:0] gain_r;
  } ctl0_t;

  // gain code to dB: five 3 dB steps, unused codes fall back to 0 dB
  function automatic logic [3:0] gain_db(input logic [2:0] code);
    logic [3:0] db;
    if (code <= 3'd4) db = {1'b0, code} + {code, 1'b0};
    else              db = 4'd0;
    return db;
  endfunction
endpackage

// File: rtl/csp_edge_sync.sv
module csp_edge_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {(STAGES + 1){RST_VAL[i]}};
        else        pipe <= {pipe[STAGES-1:0], async_in[i]};
      end
      assign level[i] = pipe[STAGES-1];
      assign rise[i]  = pipe[STAGES-1] & ~pipe[STAGES];
      assign fall[i]  = ~pipe[STAGES-1] & pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/csp_rx_frame.sv
module csp_rx_frame #(
  parameter int WORD_W = csp_pkg::WORD_W,
  parameter int ADDR_W = csp_pkg::ADDR_W,
  parameter int DATA_W = csp_pkg::DATA_W,
  parameter int CNT_W  = csp_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              frame_start,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              hdr_rd,
  output logic [DATA_W-1:0] payload,
  output logic              len_ok
);
  localparam logic [CNT_W-1:0] SAT_CNT = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] RW_CNT  = CNT_W'(ADDR_W);

  logic [WORD_W-1:0] sr;
  logic              bit_take;

  assign bit_take = frame_active & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      bit_cnt  <= '0;
      hdr_addr <= '0;
      hdr_rd   <= 1'b0;
    end else if (frame_start) begin
      bit_cnt  <= '0;
      hdr_addr <= '0;
      hdr_rd   <= 1'b0;
    end else if (bit_take) begin
      sr <= {sr[WORD_W-2:0], din};
      if (bit_cnt != SAT_CNT) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == RW_CNT) begin
        hdr_addr <= sr[ADDR_W-1:0];
        hdr_rd   <= din;
      end
    end
  end

  assign payload = sr[DATA_W-1:0];
  assign len_ok  = (bit_cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/csp_regfile.sv
module csp_regfile #(
  parameter int NUM_REGS = csp_pkg::NUM_REGS,
  parameter int ADDR_W   = csp_pkg::ADDR_W,
  parameter int DATA_W   = csp_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] reg0_q
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (wr_addr == ADDR_W'(r)) regs[r] <= wr_data;
    end
  end

  // address 0 is write-only: it never reaches the read mux
  always_comb begin
    rd_data = '0;
    for (int r = 1; r < NUM_REGS; r++)
      if (rd_addr == ADDR_W'(r)) rd_data = regs[r];
  end

  assign reg0_q = regs[0];
endmodule

// File: rtl/csp_tx.sv
module csp_tx #(
  parameter int WORD_W = csp_pkg::WORD_W,
  parameter int DATA_W = csp_pkg::DATA_W,
  parameter int CNT_W  = csp_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              sclk_fall,
  input  logic              hdr_rd,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dout
);
  logic next_bit;

  // bit_cnt = WORD_W-1-k selects payload bit k
  always_comb begin
    next_bit = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (bit_cnt == CNT_W'(WORD_W - 1 - k)) next_bit = rd_data[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dout <= 1'b0;
    else if (!frame_active) dout <= 1'b0;
    else if (sclk_fall)     dout <= hdr_rd & next_bit;
  end
endmodule

// File: rtl/ctrl_serial_regfile.sv
module ctrl_serial_regfile #(
  parameter int NUM_REGS = csp_pkg::NUM_REGS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_frame,
  input  logic       ser_din,
  output logic       ser_dout,
  output logic       peak_en,
  output logic       hpf_en,
  output logic       pwr_down,
  output logic       mod_clk_64x,
  output logic [2:0] gain_code_l,
  output logic [2:0] gain_code_r,
  output logic [3:0] gain_db_l,
  output logic [3:0] gain_db_r
);
  import csp_pkg::*;

  localparam int NSIG = 3;
  localparam int I_CLK = 0, I_FRM = 1, I_DIN = 2;

  logic [NSIG-1:0] s_lvl, s_rise, s_fall;

  // frame strobe idles high
  csp_edge_sync #(.W(NSIG), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_din, ser_frame, ser_clk}),
    .level(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  // named events for the checker
  logic              frame_active, frame_start, frame_end;
  logic              sclk_rise, sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] hdr_addr;
  logic              hdr_rd, len_ok, addr_hit, wr_fire;
  logic [DATA_W-1:0] payload, rd_data, reg0_q;
  ctl0_t             ctl0;

  assign frame_active = ~s_lvl[I_FRM];
  assign frame_start  = s_fall[I_FRM];
  assign frame_end    = s_rise[I_FRM];
  assign sclk_rise    = s_rise[I_CLK];
  assign sclk_fall    = s_fall[I_CLK];

  csp_rx_frame u_rx (
    .clk(clk), .rst_n(rst_n),
    .frame_active(frame_active), .frame_start(frame_start),
    .sclk_rise(sclk_rise), .din(s_lvl[I_DIN]),
    .bit_cnt(bit_cnt), .hdr_addr(hdr_addr), .hdr_rd(hdr_rd),
    .payload(payload), .len_ok(len_ok)
  );

  assign addr_hit = (int'(hdr_addr) < NUM_REGS);
  assign wr_fire  = frame_end & len_ok & ~hdr_rd & addr_hit;

  csp_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_addr(hdr_addr), .wr_data(payload),
    .rd_addr(hdr_addr), .rd_data(rd_data), .reg0_q(reg0_q)
  );

  csp_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .frame_active(frame_active), .sclk_fall(sclk_fall),
    .hdr_rd(hdr_rd), .bit_cnt(bit_cnt), .rd_data(rd_data),
    .dout(ser_dout)
  );

  assign ctl0        = ctl0_t'(reg0_q);
  assign peak_en     = ctl0.peak;
  assign hpf_en      = ctl0.hpf;
  assign pwr_down    = ctl0.pdn;
  assign mod_clk_64x = ctl0.mclk64;
  assign gain_code_l = ctl0.gain_l;
  assign gain_code_r = ctl0.gain_r;
  assign gain_db_l   = gain_db(ctl0.gain_l);
  assign gain_db_r   = gain_db(ctl0.gain_r);
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int ADDR_W = csp_pkg::ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_active,
  input logic              sclk_fall,
  input logic              wr_fire,
  input logic              len_ok,
  input logic [ADDR_W-1:0] hdr_addr,
  input logic              ser_dout,
  input logic [9:0]        reg0_view,
  input logic [2:0]        gain_code_l,
  input logic [2:0]        gain_code_r,
  input logic [3:0]        gain_db_l,
  input logic [3:0]        gain_db_r
);
  // R5
  wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> len_ok);

  // R7
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> !ser_dout);

  // R6
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> ($past(sclk_fall) || $past(!frame_active)));

  // R8
  reg0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && hdr_addr == '0) |=> $stable(reg0_view));

  // R3
  gain_l_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code_l > 3'd4) |-> (gain_db_l == 4'd0));

  // R3
  gain_r_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code_r > 3'd4) |-> (gain_db_r == 4'd0));

  // R3
  gain_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_db_l <= 4'd12) && (gain_db_r <= 4'd12));
endmodule

bind ctrl_serial_regfile csp_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .frame_active(frame_active), .sclk_fall(sclk_fall),
  .wr_fire(wr_fire), .len_ok(len_ok), .hdr_addr(hdr_addr),
  .ser_dout(ser_dout), .reg0_view(reg0_q),
  .gain_code_l(gain_code_l), .gain_code_r(gain_code_r),
  .gain_db_l(gain_db_l), .gain_db_r(gain_db_r)
);

// File: tb/tb_ctrl_serial_regfile.sv
`timescale 1ns/1ps
module tb_ctrl_serial_regfile;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_frame = 1'b1, ser_din = 1'b0;
  logic ser_dout, peak_en, hpf_en, pwr_down, mod_clk_64x;
  logic [2:0] gain_code_l, gain_code_r;
  logic [3:0] gain_db_l, gain_db_r;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctrl_serial_regfile dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame(ser_frame),
    .ser_din(ser_din), .ser_dout(ser_dout), .peak_en(peak_en),
    .hpf_en(hpf_en), .pwr_down(pwr_down), .mod_clk_64x(mod_clk_64x),
    .gain_code_l(gain_code_l), .gain_code_r(gain_code_r),
    .gain_db_l(gain_db_l), .gain_db_r(gain_db_r)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_db(input logic [2:0] c);
    case (c)
      3'd1: return 4'd3;
      3'd2: return 4'd6;
      3'd3: return 4'd9;
      3'd4: return 4'd12;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] mkword(input logic [3:0] a, input logic rd,
                                         input logic rsv, input logic [9:0] d);
    return {a, rd, rsv, d};
  endfunction

  // sends the first nbits of w (a 17th bit is 0); gathers payload-time dout
  task automatic xfer(input logic [15:0] w, input int nbits,
                      output logic [9:0] rdv, output logic stray);
    rdv = '0; stray = 1'b0;
    @(negedge clk); ser_frame = 1'b0; ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 1; i <= nbits; i++) begin
      ser_clk = 1'b0;
      ser_din = (i <= 16) ? w[16 - i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 7 && i <= 16) rdv[16 - i] = ser_dout;
      else if (ser_dout) stray = 1'b1;
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    if (ser_dout) stray = 1'b1;
    ser_frame = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    if (ser_dout) stray = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [9:0] d, input logic rsv = 1'b0);
    logic [9:0] r; logic s;
    xfer(mkword(a, 1'b0, rsv, d), 16, r, s);
    check("R7 dout quiet in write frame", s, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [9:0] v);
    logic s;
    xfer(mkword(a, 1'b1, 1'b0, 10'h155), 16, v, s);
    check("R7 dout quiet outside payload", s, 1'b0);
  endtask

  task automatic check_reg0(input string req, input logic [9:0] d);
    check({req, " peak_en"},     peak_en,     d[9]);
    check({req, " hpf_en"},      hpf_en,      d[8]);
    check({req, " pwr_down"},    pwr_down,    d[7]);
    check({req, " mod_clk_64x"}, mod_clk_64x, d[6]);
    check({req, " gain_code_l"}, gain_code_l, d[5:3]);
    check({req, " gain_code_r"}, gain_code_r, d[2:0]);
    check({req, " gain_db_l"},   gain_db_l,   exp_db(d[5:3]));
    check({req, " gain_db_r"},   gain_db_r,   exp_db(d[2:0]));
  endtask

  task automatic t_reset();
    check_reg0("R4 reset", 10'd0);
    check("R4 reset dout", ser_dout, 1'b0);
  endtask

  task automatic t_fields();
    wr(4'd0, 10'b1010_011_100);
    check_reg0("R1 pattern A", 10'b1010_011_100);
    wr(4'd0, 10'b0101_001_010);
    check_reg0("R1 pattern B", 10'b0101_001_010);
  endtask

  task automatic t_gain_sweep();
    for (int c = 0; c < 8; c++) begin
      logic [2:0] l, r;
      l = 3'(c); r = 3'(7 - c);
      wr(4'd0, {4'b0000, l, r});
      check("R2 left code", gain_code_l, l);
      check("R2 right code", gain_code_r, r);
      check("R3 left dB", gain_db_l, exp_db(l));
      check("R3 right dB", gain_db_r, exp_db(r));
    end
  endtask

  task automatic t_bad_length();
    logic [9:0] v; logic s;
    wr(4'd0, 10'b1100_010_001);
    xfer(mkword(4'd0, 1'b0, 1'b0, 10'b0011_100_011), 15, v, s);
    check_reg0("R5 short frame", 10'b1100_010_001);
    xfer(mkword(4'd0, 1'b0, 1'b0, 10'b0011_100_011), 17, v, s);
    check_reg0("R5 long frame", 10'b1100_010_001);
    wr(4'd1, 10'h0AA);
    xfer(mkword(4'd1, 1'b0, 1'b0, 10'h311), 15, v, s);
    xfer(mkword(4'd1, 1'b0, 1'b0, 10'h322), 17, v, s);
    rd(4'd1, v);
    check("R5 reg1 after bad frames", v, 10'h0AA);
  endtask

  task automatic t_readback();
    logic [9:0] v;
    wr(4'd1, 10'h2A5);
    wr(4'd2, 10'h15A);
    wr(4'd3, 10'h3FF);
    rd(4'd1, v); check("R6 read reg1", v, 10'h2A5);
    rd(4'd2, v); check("R6 read reg2", v, 10'h15A);
    rd(4'd3, v); check("R6 read reg3", v, 10'h3FF);
  endtask

  task automatic t_write_only();
    logic [9:0] v;
    wr(4'd0, 10'b1111_100_011);
    rd(4'd0, v);
    check("R8 read of address 0", v, 10'd0);
    check_reg0("R8 reg0 kept", 10'b1111_100_011);
  endtask

  task automatic t_ignored();
    logic [9:0] v;
    wr(4'd9, 10'h0F0);
    wr(4'd4, 10'h1E1);
    rd(4'd1, v); check("R9 reg1 untouched", v, 10'h2A5);
    rd(4'd2, v); check("R9 reg2 untouched", v, 10'h15A);
    rd(4'd3, v); check("R9 reg3 untouched", v, 10'h3FF);
    check_reg0("R9 reg0 untouched", 10'b1111_100_011);
    rd(4'd9, v); check("R9 read out of range", v, 10'd0);
    wr(4'd2, 10'h0C3, 1'b1);
    rd(4'd2, v); check("R9 reserved bit ignored", v, 10'h0C3);
    wr(4'd0, 10'b0010_100_000, 1'b1);
    check_reg0("R9 reserved bit reg0", 10'b0010_100_000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_fields();
    t_gain_sweep();
    t_bad_length();
    t_readback();
    t_write_only();
    t_ignored();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule